// File: doc/BRIEF.md
# Virtually Tagged Data Cache with Per-Page Inhibit

This block is a small direct-mapped data cache placed between a processor load/store port and a memory bus. The virtual address of each access serves as both index and tag. No physical address is held anywhere in the cache. Because the tags are virtual, the cache cannot watch traffic from other bus masters such as DMA engines. Software has to clear it with an invalidate-all command whenever memory may have changed behind its back.

Each access arrives with two flags from the address-translation lookup:

- A page-valid flag. An access to an invalid page completes at once with a fault indication. It starts no bus cycle and does not touch the cache.
- A cache-inhibit flag. An inhibited access is forced to miss even when a matching line is present. It always goes to the bus. It neither fills nor updates a line, which suits device registers and buffers shared with other masters.

Cacheable read misses fill a one-word line. Stores are write-through and never allocate.

Top module: `vtag_cache`

## Requirements
- R1: After reset every line is invalid, `cpuReady` and `busReq` are low, and the first read of any address, including address 0, goes to the bus.
- R2: A cacheable read that misses issues a single bus read. It returns `busRdata` with `cpuReady` high in the `busAck` cycle and fills the line. A later cacheable read of the same address completes in the cycle it is presented, with no bus cycle, and returns the stored word.
- R3: The cache is direct-mapped with word lines. Bits [1:0] of the address are ignored, bits [5:2] select the line, and bits [31:6] are the tag. An address with the same index but a different tag misses and replaces the line.
- R4: An inhibited read always uses the bus, even when the line holds a matching valid tag. It neither allocates a line nor alters one, so a cached line keeps its old word and an uncached address stays uncached.
- R5: Every store drives a bus write of `cpuWdata`. A cacheable store that hits also updates the line, and a cacheable store that misses allocates nothing.
- R6: An inhibited store writes the bus only. A line cached for that address keeps its previous word.
- R7: `invalidateAll` clears every line in one cycle. An access presented in that cycle gets `cpuReady` low and starts no bus cycle, then proceeds once the command drops.
- R8: An access with `cpuPageValid` low completes in its first cycle with `cpuFault` and `cpuReady` high. It starts no bus cycle and changes no line.
- R9: While `busReq` is high and `busAck` has not arrived, `busAddr`, `busWe` and `busWdata` hold steady and `cpuReady` stays low.
- R10: Memory changed by another master is not seen through a cached line. The stale word is returned until an invalidate-all, after which the next read fetches the new word.
- R11: An invalidate-all that coincides with the `busAck` of a cacheable read still returns the bus data, but leaves that line invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor access request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Virtual byte address |
| cpuWdata | input | 32 | Store data |
| cpuInhibit | input | 1 | Page is cache-inhibited |
| cpuPageValid | input | 1 | Page descriptor is valid |
| invalidateAll | input | 1 | Clear every line this cycle |
| cpuReady | output | 1 | Access completes this cycle |
| cpuRdata | output | 32 | Load data, valid with `cpuReady` |
| cpuFault | output | 1 | Access hit an invalid page |
| busReq | output | 1 | Bus transfer request |
| busWe | output | 1 | Bus transfer is a write |
| busAddr | output | 32 | Bus address |
| busWdata | output | 32 | Bus write data |
| busAck | input | 1 | Bus transfer done, one cycle |
| busRdata | input | 32 | Bus read data, valid with `busAck` |

## Verification
The embedded properties assume the processor keeps `cpuReq` and its address, data, inhibit and page flags steady from presentation until `cpuReady`. They also assume the bus raises `busAck` for exactly one cycle and only while `busReq` is high. The bench drives every access from a single task that changes inputs only after a completing edge. Its bus responder acknowledges a pending request after a fixed two-cycle wait and then drops `busAck`, so the stimulus stays inside these assumptions. Memory changes made by another master are modelled by writing the bench memory directly, which the cache cannot see.

// File: rtl/vtag_cache_pkg.sv
package vtag_cache_pkg;

  typedef struct packed {
    logic latchReq;    // capture the access into the request register
    logic fillLine;    // write bus data, tag and valid into the indexed line
    logic updateLine;  // write store data into the indexed line
    logic clearAll;    // drop every valid bit
    logic selBusData;  // return bus data instead of line data
  } ctrlStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUS  = 1'b1
  } ctrlState_t;

endpackage

// File: rtl/vtag_cache_dp.sv
module vtag_cache_dp
  import vtag_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] busRdata,
  output logic              lineHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWe
);

  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [ADDR_W-1:0] reqAddrQ;
  logic [DATA_W-1:0] reqWdataQ;
  logic              reqWeQ;

  logic [IDX_W-1:0] cpuIdx;
  logic [TAG_W-1:0] cpuTag;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;

  logic [TAG_W-1:0]  lineTag   [LINES];
  logic [DATA_W-1:0] lineData  [LINES];
  logic              lineValid [LINES];

  assign cpuIdx = cpuAddr[OFF_W +: IDX_W];
  assign cpuTag = cpuAddr[ADDR_W-1 -: TAG_W];
  assign reqIdx = reqAddrQ[OFF_W +: IDX_W];
  assign reqTag = reqAddrQ[ADDR_W-1 -: TAG_W];

  // Request register: holds the access for the whole bus transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ  <= '0;
      reqWdataQ <= '0;
      reqWeQ    <= 1'b0;
    end else if (strobes.latchReq) begin
      reqAddrQ  <= cpuAddr;
      reqWdataQ <= cpuWdata;
      reqWeQ    <= cpuWe;
    end
  end

  // One storage slice per line
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [TAG_W-1:0]  tagQ;
    logic [DATA_W-1:0] dataQ;
    logic              validQ;
    logic              selThis;

    assign selThis = (reqIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
      end else if (strobes.clearAll) begin
        validQ <= 1'b0;
      end else if (strobes.fillLine && selThis) begin
        validQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (strobes.fillLine && selThis) begin
        tagQ  <= reqTag;
        dataQ <= busRdata;
      end else if (strobes.updateLine && selThis) begin
        dataQ <= reqWdataQ;
      end
    end

    assign lineTag[g]   = tagQ;
    assign lineData[g]  = dataQ;
    assign lineValid[g] = validQ;
  end

  assign lineHit  = lineValid[cpuIdx] && (lineTag[cpuIdx] == cpuTag);
  assign cpuRdata = strobes.selBusData ? busRdata : lineData[cpuIdx];

  assign busAddr  = reqAddrQ;
  assign busWdata = reqWdataQ;
  assign busWe    = reqWeQ;

  // R7
  flush_no_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !lineHit);

endmodule

// File: rtl/vtag_cache_ctrl.sv
module vtag_cache_ctrl
  import vtag_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic         cpuInhibit,
  input  logic         cpuPageValid,
  input  logic         invalidateAll,
  input  logic         lineHit,
  input  logic         busAck,
  output logic         cpuReady,
  output logic         cpuFault,
  output logic         busReq,
  output ctrlStrobes_t strobes
);

  ctrlState_t stateQ, stateD;
  logic pendWeQ, pendCacheableQ, pendHitQ;

  always_comb begin
    stateD   = stateQ;
    strobes  = '0;
    cpuReady = 1'b0;
    cpuFault = 1'b0;
    busReq   = 1'b0;
    strobes.clearAll = invalidateAll;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq && !invalidateAll) begin
          if (!cpuPageValid) begin
            cpuReady = 1'b1;
            cpuFault = 1'b1;
          end else if (!cpuWe && !cpuInhibit && lineHit) begin
            cpuReady = 1'b1;
          end else begin
            strobes.latchReq = 1'b1;
            stateD = ST_BUS;
          end
        end
      end
      ST_BUS: begin
        busReq = 1'b1;
        if (busAck) begin
          cpuReady           = 1'b1;
          strobes.selBusData = 1'b1;
          strobes.fillLine   = pendCacheableQ && !pendWeQ && !invalidateAll;
          strobes.updateLine = pendCacheableQ && pendWeQ && pendHitQ;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ         <= ST_IDLE;
      pendWeQ        <= 1'b0;
      pendCacheableQ <= 1'b0;
      pendHitQ       <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobes.latchReq) begin
        pendWeQ        <= cpuWe;
        pendCacheableQ <= !cpuInhibit;
        pendHitQ       <= lineHit;
      end
    end
  end

  // R4
  inhibit_goes_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && cpuReq && !invalidateAll && cpuPageValid && cpuInhibit)
      |=> busReq);

  // R7
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invalidateAll && stateQ == ST_IDLE) |-> !cpuReady);

  // R9
  ready_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> ((busReq && busAck) || cpuFault || (lineHit && !cpuWe && !cpuInhibit)));

endmodule

// File: rtl/vtag_cache.sv
module vtag_cache
  import vtag_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuInhibit,
  input  logic              cpuPageValid,
  input  logic              invalidateAll,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuFault,
  output logic              busReq,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdata
);

  ctrlStrobes_t strobes;
  logic         lineHit;

  vtag_cache_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .cpuInhibit   (cpuInhibit),
    .cpuPageValid (cpuPageValid),
    .invalidateAll(invalidateAll),
    .lineHit      (lineHit),
    .busAck       (busAck),
    .cpuReady     (cpuReady),
    .cpuFault     (cpuFault),
    .busReq       (busReq),
    .strobes      (strobes)
  );

  vtag_cache_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .cpuWe   (cpuWe),
    .busRdata(busRdata),
    .lineHit (lineHit),
    .cpuRdata(cpuRdata),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWe   (busWe)
  );

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWe) && $stable(busWdata)));

  // R8
  fault_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuFault |=> !busReq);

endmodule

// File: tb/vtag_cache_tb.sv
module vtag_cache_tb;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuReq, cpuWe, cpuInhibit, cpuPageValid, invalidateAll;
  logic [31:0] cpuAddr, cpuWdata;
  logic        cpuReady, cpuFault;
  logic [31:0] cpuRdata;
  logic        busReq, busWe, busAck;
  logic [31:0] busAddr, busWdata, busRdata;

  always #(CLK_NS / 2) clk = ~clk;

  vtag_cache u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuInhibit(cpuInhibit), .cpuPageValid(cpuPageValid),
    .invalidateAll(invalidateAll), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .cpuFault(cpuFault), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata)
  );

  int unsigned vectors = 0;
  int unsigned miscompares = 0;
  int          busTxn = 0;
  bit          finished = 0;

  logic [31:0] mem [logic [29:0]];

  function automatic logic [31:0] memRead(logic [31:0] a);
    if (mem.exists(a[31:2])) return mem[a[31:2]];
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    bit          isRead;
    logic [31:0] data;
    bit          fault;
    int          busExp;
    int          busStart;
    string       req;
  } expItem_t;

  expItem_t sbQ[$];

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && busReq && !busAck)
        chk(!cpuReady, "R9", "ready while bus pending", 32'(cpuReady), 32'd0);
      if (rstN && cpuReq && cpuReady) begin
        if (sbQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected completion", 32'd1, 32'd0);
        end else begin
          expItem_t it;
          it = sbQ.pop_front();
          chk(cpuFault == it.fault, it.req, "fault", 32'(cpuFault), 32'(it.fault));
          if (it.isRead && !it.fault)
            chk(cpuRdata == it.data, it.req, "read data", cpuRdata, it.data);
          chk((busTxn - it.busStart) == it.busExp, it.req, "bus transfers",
              32'(busTxn - it.busStart), 32'(it.busExp));
        end
      end
    end
  end

  // Bus responder: acknowledges after a two-cycle wait, checks hold stability
  initial begin
    int          waitCnt;
    bit          holding;
    bit          broken;
    logic [31:0] hAddr, hWd;
    logic        hWe;
    waitCnt = 0; holding = 0; broken = 0; hAddr = '0; hWd = '0; hWe = 0;
    busAck = 1'b0;
    busRdata = '0;
    forever begin
      @(posedge clk);
      if (busReq && !busAck) begin
        if (holding && (busAddr != hAddr || busWe != hWe || busWdata != hWd)) broken = 1;
        if (!holding) begin
          hAddr = busAddr; hWe = busWe; hWd = busWdata; holding = 1;
        end
        waitCnt++;
        if (waitCnt == 2) begin
          chk(!broken, "R9", "bus fields held until ack", busAddr, hAddr);
          busAck   <= 1'b1;
          busRdata <= memRead(busAddr);
          if (busWe) mem[busAddr[31:2]] = busWdata;
          busTxn++;
          waitCnt = 0; holding = 0; broken = 0;
        end
      end else begin
        busAck <= 1'b0;
      end
    end
  end

  task automatic access(bit we, logic [31:0] addr, logic [31:0] wdata, bit inh, bit pv,
                        logic [31:0] expData, int busExp, string req, bit inval = 0);
    expItem_t it;
    @(posedge clk); #2;
    cpuReq = 1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    cpuInhibit = inh; cpuPageValid = pv;
    it.isRead = !we; it.data = expData; it.fault = !pv;
    it.busExp = busExp; it.busStart = busTxn; it.req = req;
    sbQ.push_back(it);
    if (inval) begin
      invalidateAll = 1;
      @(negedge clk);
      chk(!cpuReady, "R7", "ready during invalidate", 32'(cpuReady), 32'd0);
      chk(!busReq, "R7", "bus during invalidate", 32'(busReq), 32'd0);
      @(posedge clk); #2;
      invalidateAll = 0;
    end
    @(negedge clk);
    while (!cpuReady) @(negedge clk);
    @(posedge clk); #2;
    cpuReq = 0;
  endtask

  task automatic flush();
    @(posedge clk); #2;
    invalidateAll = 1;
    @(posedge clk); #2;
    invalidateAll = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h0000_1010;
  localparam logic [31:0] B = 32'h0000_1050;  // same index as A, other tag
  localparam logic [31:0] C = 32'h0000_2024;
  localparam logic [31:0] E = 32'h0000_3038;
  localparam logic [31:0] F = 32'h0000_400C;
  localparam logic [31:0] G = 32'h0000_5000;

  initial begin
    logic [31:0] oldA, oldF;
    rstN = 0; cpuReq = 0; cpuWe = 0; cpuAddr = '0; cpuWdata = '0;
    cpuInhibit = 0; cpuPageValid = 1; invalidateAll = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cpuReady, "R1", "ready in reset", 32'(cpuReady), 32'd0);
    chk(!busReq, "R1", "busReq in reset", 32'(busReq), 32'd0);
    @(posedge clk); #2;
    rstN = 1;

    // R1: nothing valid after reset, even address 0
    access(0, 32'h0, '0, 0, 1, memRead(32'h0), 1, "R1");
    // R2: miss fills, then zero-wait hit
    access(0, A, '0, 0, 1, memRead(A), 1, "R2");
    access(0, A, '0, 0, 1, memRead(A), 0, "R2");
    // R3: same index, other tag evicts
    access(0, B, '0, 0, 1, memRead(B), 1, "R3");
    access(0, A, '0, 0, 1, memRead(A), 1, "R3");
    oldA = memRead(A);
    // R4 / R10: inhibited read bypasses a matching line and leaves it alone
    mem[A[31:2]] = 32'hCAFE_0001;
    access(0, A, '0, 1, 1, 32'hCAFE_0001, 1, "R4");
    access(0, A, '0, 0, 1, oldA, 0, "R4");
    access(0, C, '0, 1, 1, memRead(C), 1, "R4");
    access(0, C, '0, 0, 1, memRead(C), 1, "R4");
    access(0, C, '0, 0, 1, memRead(C), 0, "R4");
    // R5: write-through hit updates line; miss does not allocate
    access(1, A, 32'h1111_2222, 0, 1, '0, 1, "R5");
    chk(memRead(A) == 32'h1111_2222, "R5", "memory after store", memRead(A), 32'h1111_2222);
    access(0, A, '0, 0, 1, 32'h1111_2222, 0, "R5");
    access(1, E, 32'h3333_4444, 0, 1, '0, 1, "R5");
    access(0, E, '0, 0, 1, 32'h3333_4444, 1, "R5");
    // R6: inhibited store reaches bus only
    access(1, A, 32'h5555_6666, 1, 1, '0, 1, "R6");
    chk(memRead(A) == 32'h5555_6666, "R6", "memory after inhibited store", memRead(A), 32'h5555_6666);
    access(0, A, '0, 0, 1, 32'h1111_2222, 0, "R6");
    // R8: invalid page faults without bus or cache effect
    access(0, A, '0, 0, 0, '0, 0, "R8");
    access(1, A, 32'hDEAD_BEEF, 0, 0, '0, 0, "R8");
    access(0, A, '0, 1, 0, '0, 0, "R8");
    chk(memRead(A) == 32'h5555_6666, "R8", "memory after faulted store", memRead(A), 32'h5555_6666);
    access(0, A, '0, 0, 1, 32'h1111_2222, 0, "R8");
    // R7: invalidate with a simultaneous access
    access(0, A, '0, 0, 1, 32'h5555_6666, 1, "R7", 1);
    access(0, C, '0, 0, 1, memRead(C), 1, "R7");
    // R10: stale until explicit invalidate
    access(0, F, '0, 0, 1, memRead(F), 1, "R10");
    oldF = memRead(F);
    mem[F[31:2]] = 32'hBEEF_0000;
    access(0, F, '0, 0, 1, oldF, 0, "R10");
    flush();
    access(0, F, '0, 0, 1, 32'hBEEF_0000, 1, "R10");
    // R11: invalidate in the ack cycle of a fill
    fork
      access(0, G, '0, 0, 1, memRead(G), 1, "R11");
      begin
        wait (busAck === 1'b1);
        #1 invalidateAll = 1;
        @(posedge clk); #2;
        invalidateAll = 0;
      end
    join
    access(0, G, '0, 0, 1, memRead(G), 1, "R11");

    repeat (4) @(posedge clk);
    chk(sbQ.size() == 0, "R2", "scoreboard drained", 32'(sbQ.size()), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule